// File: doc/BRIEF.md
# NAND Flash Asynchronous Bus Sequencer

This block sits between an on-chip host and one asynchronous NAND flash bus of 8 data bits. The host offers one byte transaction at a time. The sequencer plays each transaction out on the flash pins as three timed phases: address/data setup, strobe, and hold. The length of each phase is read from a 32-bit timing word. A write that follows a read is preceded by a programmable bus turnaround gap. The command-latch and address-latch pins are not programmed directly. They come from two host address bits, so software selects a command or address cycle by the offset it writes to.

The host request side uses valid/ready. A transfer takes place in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle and flash mode is enabled. The host must hold `req_write`, `req_addr` and `req_wdata` steady while `req_valid` is high and the transfer has not happened yet. The response side has no back-pressure: `rsp_valid` pulses for one cycle, and during that cycle `rsp_rdata` carries the byte a read sampled. The flash ready/busy line is one wired-AND signal shared by all devices. It is registered and presented as a status bit.

Top module: `nand_ebc_top`

## Requirements
- R1: While reset is held, the pins are idle: `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, `rsp_valid` is low and `rdy_status` is 0.
- R2: `req_ready` is high exactly when no transaction is in progress and `cfg_nand_en` is 1. While `cfg_nand_en` is 0, a pending request is never taken and the pins stay idle.
- R3: A write uses the write setup field cfg[29:26], the write strobe field cfg[25:20] and the write hold field cfg[19:17]. Each phase lasts its field value plus one cycle. `nand_ce_n` is low across all three phases, and `nand_we_n` is low only during the strobe phase.
- R4: During every cycle in which a write holds `nand_ce_n` low, `nand_dq_oe` is 1 and `nand_dq_out` equals the accepted write byte. `nand_dq_oe` is 0 at all other times.
- R5: A read uses the read setup field cfg[16:13], the read strobe field cfg[12:7] and the read hold field cfg[6:4]. Each phase lasts its field value plus one cycle. `nand_re_n` is low only during the strobe phase.
- R6: A read returns, on `rsp_rdata` with its `rsp_valid` pulse, the value that `nand_dq_in` had in the last cycle of its read strobe phase.
- R7: While `nand_ce_n` is low, `nand_cle` equals request address bit 4 and `nand_ale` equals address bit 3. Both are low while `nand_ce_n` is high. Address bits 1:0 have no effect.
- R8: Each accepted request produces exactly one `rsp_valid` pulse, in the last cycle of its hold phase. The block is idle in the following cycle.
- R9: A write accepted after a read inserts cfg[3:2]+1 cycles with idle pins before its setup phase. No gap is inserted after a write or between reads.
- R10: `rdy_status` equals the `nand_rb` value of the previous cycle, where 1 means ready.
- R11: The phase lengths are taken from `cfg_timing` when the request is accepted. Changing the word during a transaction does not change that transaction's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timing | input | 32 | Packed phase timing word |
| cfg_nand_en | input | 1 | Flash mode enable for this chip select |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host byte address (bit 4 selects CLE, bit 3 selects ALE) |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read byte, meaningful with rsp_valid after a read |
| rdy_status | output | 1 | Registered flash ready status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dq_out | output | DATA_W | Data driven to flash |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_in | input | DATA_W | Data from flash |
| nand_rb | input | 1 | Shared ready/busy line, 1 = ready |

## Verification
The assertions take `nand_rb` and `cfg_nand_en` to be known, non-X levels. They also take the request fields to be stable while a request is offered and not yet taken. They do not depend on any particular timing word, so they hold for any value of `cfg_timing`, including one that changes during a transaction. The stimulus changes every input half a cycle away from the sampling edge. It holds the request fields steady from the moment `req_valid` rises until the transfer happens. It changes `cfg_timing` only while the sequencer is idle, except in one deliberate case that exercises the snapshot rule.

// File: rtl/nand_ebc_pkg.sv
package nand_ebc_pkg;
  // fixed positions of the packed timing word
  localparam int WS_LSB  = 26;
  localparam int WS_W    = 4;
  localparam int WST_LSB = 20;
  localparam int WST_W   = 6;
  localparam int WH_LSB  = 17;
  localparam int WH_W    = 3;
  localparam int RS_LSB  = 13;
  localparam int RS_W    = 4;
  localparam int RST_LSB = 7;
  localparam int RST_W   = 6;
  localparam int RH_LSB  = 4;
  localparam int RH_W    = 3;
  localparam int TA_LSB  = 2;
  localparam int TA_W    = 2;

  // counter wide enough for the widest field
  localparam int PH_W = (WST_W > RST_W) ? WST_W : RST_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [PH_W-1:0] turn;
    logic [PH_W-1:0] setup;
    logic [PH_W-1:0] strobe;
    logic [PH_W-1:0] hold;
  } phase_len_t;

  function automatic phase_len_t pick_len(input logic [31:0] w, input logic wr);
    phase_len_t l;
    l.turn = PH_W'(w[TA_LSB +: TA_W]);
    if (wr) begin
      l.setup  = PH_W'(w[WS_LSB  +: WS_W]);
      l.strobe = PH_W'(w[WST_LSB +: WST_W]);
      l.hold   = PH_W'(w[WH_LSB  +: WH_W]);
    end else begin
      l.setup  = PH_W'(w[RS_LSB  +: RS_W]);
      l.strobe = PH_W'(w[RST_LSB +: RST_W]);
      l.hold   = PH_W'(w[RH_LSB  +: RH_W]);
    end
    return l;
  endfunction
endpackage

// File: rtl/nand_ebc_seq.sv
module nand_ebc_seq
  import nand_ebc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_wr,
  input  phase_len_t len_in,
  output phase_e     phase,
  output logic       last
);
  phase_len_t      len_q;
  logic [PH_W-1:0] cnt;
  logic            wr_q;
  logic            prev_rd;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      len_q   <= '0;
      wr_q    <= 1'b0;
      prev_rd <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            len_q <= len_in;
            wr_q  <= start_wr;
            if (start_wr && prev_rd) begin
              phase <= PH_TURN;
              cnt   <= len_in.turn;
            end else begin
              phase <= PH_SETUP;
              cnt   <= len_in.setup;
            end
          end
        end
        PH_TURN: begin
          if (!last) cnt <= cnt - 1'b1;
          else begin
            phase <= PH_SETUP;
            cnt   <= len_q.setup;
          end
        end
        PH_SETUP: begin
          if (!last) cnt <= cnt - 1'b1;
          else begin
            phase <= PH_STROBE;
            cnt   <= len_q.strobe;
          end
        end
        PH_STROBE: begin
          if (!last) cnt <= cnt - 1'b1;
          else begin
            phase <= PH_HOLD;
            cnt   <= len_q.hold;
          end
        end
        PH_HOLD: begin
          if (!last) cnt <= cnt - 1'b1;
          else begin
            phase   <= PH_IDLE;
            prev_rd <= !wr_q;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_ebc_pins.sv
module nand_ebc_pins
  import nand_ebc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wr,
  input  logic              load_cle,
  input  logic              load_ale,
  input  logic [DATA_W-1:0] load_data,
  input  phase_e            phase,
  input  logic              last,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              we_n,
  output logic              re_n,
  output logic              cle,
  output logic              ale,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);
  logic              wr_q;
  logic              cle_q;
  logic              ale_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              active;
  logic              strobe;

  assign active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe = (phase == PH_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load) begin
        wr_q    <= load_wr;
        cle_q   <= load_cle;
        ale_q   <= load_ale;
        wdata_q <= load_data;
      end
      if (strobe && last && !wr_q) rdata_q <= dq_in;
    end
  end

  assign ce_n   = !active;
  assign we_n   = !(strobe && wr_q);
  assign re_n   = !(strobe && !wr_q);
  assign cle    = active && cle_q;
  assign ale    = active && ale_q;
  assign dq_oe  = active && wr_q;
  assign dq_out = wdata_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/nand_ebc_rdy.sv
module nand_ebc_rdy (
  input  logic clk,
  input  logic rst_n,
  input  logic rb,
  output logic rdy_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rb;
  end
endmodule

// File: rtl/nand_ebc_top.sv
module nand_ebc_top
  import nand_ebc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CLE_BIT = 4,
  parameter int ALE_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_timing,
  input  logic              cfg_nand_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rdy_status,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb
);
  phase_e     phase;
  logic       last;
  logic       fire;
  phase_len_t len_in;
  logic       addr_unused;
  logic       cfg_unused;

  // address bits other than the two latch selects carry no meaning here
  assign addr_unused = ^{req_addr[ADDR_W-1:CLE_BIT+1], req_addr[ALE_BIT-1:0]};
  assign cfg_unused  = ^{cfg_timing[31:30], cfg_timing[1:0]};

  assign req_ready = (phase == PH_IDLE) && cfg_nand_en;
  assign fire      = req_valid && req_ready;
  assign len_in    = pick_len(cfg_timing, req_write);
  assign rsp_valid = (phase == PH_HOLD) && last;

  nand_ebc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fire),
    .start_wr (req_write),
    .len_in   (len_in),
    .phase    (phase),
    .last     (last)
  );

  nand_ebc_pins #(.DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .load_wr   (req_write),
    .load_cle  (req_addr[CLE_BIT]),
    .load_ale  (req_addr[ALE_BIT]),
    .load_data (req_wdata),
    .phase     (phase),
    .last      (last),
    .dq_in     (nand_dq_in),
    .ce_n      (nand_ce_n),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .dq_out    (nand_dq_out),
    .dq_oe     (nand_dq_oe),
    .rdata     (rsp_rdata)
  );

  nand_ebc_rdy u_rdy (
    .clk   (clk),
    .rst_n (rst_n),
    .rb    (nand_rb),
    .rdy_q (rdy_status)
  );
endmodule

// File: rtl/nand_ebc_chk.sv
module nand_ebc_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_nand_en,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rdy_status,
  input logic              nand_ce_n,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic [DATA_W-1:0] nand_dq_out,
  input logic              nand_dq_oe,
  input logic              nand_rb
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_nand_en |-> !req_ready); // R2
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (!nand_ce_n && nand_re_n)); // R3
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> (!nand_ce_n && nand_re_n)); // R4
  AST_DQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |=> (nand_dq_oe |-> $stable(nand_dq_out))); // R4
  AST_RE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_ce_n && nand_we_n)); // R5
  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (!nand_cle && !nand_ale)); // R7
  AST_ACK_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!nand_ce_n && nand_we_n && nand_re_n)); // R8
  AST_ACK_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (nand_ce_n && !rsp_valid)); // R8
  AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rdy_status == $past(nand_rb))); // R10
endmodule

bind nand_ebc_top nand_ebc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_nand_en (cfg_nand_en),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rdy_status  (rdy_status),
  .nand_ce_n   (nand_ce_n),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_dq_out (nand_dq_out),
  .nand_dq_oe  (nand_dq_oe),
  .nand_rb     (nand_rb)
);

// File: tb/sim_nand_ebc_top.sv
module sim_nand_ebc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_timing;
  logic        cfg_nand_en;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        rdy_status;
  logic        nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in;
  logic        nand_rb;

  always #10 clk = ~clk;

  nand_ebc_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing), .cfg_nand_en(cfg_nand_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rdy_status(rdy_status), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  typedef struct {
    bit    ce_n, we_n, re_n, cle, ale, oe, ack, rd, cap;
    int    dq;
    string tg;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   cap_val = 0;
  bit   last_rd = 0;
  bit   m_rb = 0;
  bit   run = 0;
  int   cyc = 0;
  int   wd = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t idle_e(input string tag);
    exp_t e;
    e.ce_n = 1; e.we_n = 1; e.re_n = 1; e.cle = 0; e.ale = 0; e.oe = 0;
    e.ack = 0; e.rd = 0; e.cap = 0; e.dq = 0; e.tg = tag;
    return e;
  endfunction

  function automatic logic [31:0] mkcfg(input int ws, input int wst, input int wh,
      input int rs, input int rst, input int rh, input int ta);
    return 32'((ws << 26) | (wst << 20) | (wh << 17) | (rs << 13) | (rst << 7) | (rh << 4) | (ta << 2));
  endfunction

  // reference model: the expected pin state of each future cycle
  function automatic void build(input bit wr, input logic [15:0] a, input logic [7:0] d,
                                input logic [31:0] t);
    int   s, st, h, ta;
    exp_t e;
    ta = int'((t >> 2) & 3);
    if (wr) begin
      s = int'((t >> 26) & 15); st = int'((t >> 20) & 63); h = int'((t >> 17) & 7);
    end else begin
      s = int'((t >> 13) & 15); st = int'((t >> 7) & 63); h = int'((t >> 4) & 7);
    end
    if (wr && last_rd)
      for (int i = 0; i <= ta; i++) q.push_back(idle_e("R9"));
    e = idle_e(wr ? "R3" : "R5");
    e.ce_n = 0; e.cle = a[4]; e.ale = a[3]; e.oe = wr; e.dq = int'(d); e.rd = !wr;
    for (int i = 0; i <= s; i++) q.push_back(e);
    e.we_n = !wr; e.re_n = wr;
    for (int i = 0; i <= st; i++) begin
      e.cap = (i == st) && !wr;
      q.push_back(e);
    end
    e.cap = 0; e.we_n = 1; e.re_n = 1;
    for (int i = 0; i <= h; i++) begin
      e.ack = (i == h);
      q.push_back(e);
    end
    last_rd = !wr;
  endfunction

  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      q.delete();
      last_rd = 0;
      m_rb = 0;
    end else begin
      m_rb = nand_rb;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.cap) cap_val = int'(nand_dq_in);
      end else if (req_valid && cfg_nand_en) begin
        build(req_write, req_addr, req_wdata, cfg_timing);
      end
    end
  end

  // compare against the model away from the clock edges
  always begin
    exp_t e;
    @(negedge clk);
    #5;
    if (run) begin
      e = (q.size() > 0) ? q[0] : idle_e("R2");
      chk(nand_ce_n == e.ce_n, e.tg, int'(nand_ce_n), int'(e.ce_n));
      chk(nand_we_n == e.we_n, "R3", int'(nand_we_n), int'(e.we_n));
      chk(nand_re_n == e.re_n, "R5", int'(nand_re_n), int'(e.re_n));
      chk(nand_cle == e.cle, "R7", int'(nand_cle), int'(e.cle));
      chk(nand_ale == e.ale, "R7", int'(nand_ale), int'(e.ale));
      chk(nand_dq_oe == e.oe, "R4", int'(nand_dq_oe), int'(e.oe));
      if (e.oe) chk(int'(nand_dq_out) == e.dq, "R4", int'(nand_dq_out), e.dq);
      chk(rsp_valid == e.ack, "R8", int'(rsp_valid), int'(e.ack));
      if (e.ack && e.rd) chk(int'(rsp_rdata) == cap_val, "R6", int'(rsp_rdata), cap_val);
      chk(req_ready == ((q.size() == 0) && cfg_nand_en), "R2", int'(req_ready),
          int'((q.size() == 0) && cfg_nand_en));
      chk(rdy_status == m_rb, "R10", int'(rdy_status), int'(m_rb));
    end
  end

  // flash-side stimulus changes every cycle
  always @(negedge clk) begin
    cyc++;
    nand_dq_in = 8'((cyc * 37 + 11) & 255);
    nand_rb    = (cyc % 5) != 0;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", wd, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic op(input bit wr, input logic [15:0] a, input logic [7:0] d,
                    input bit chg = 0, input logic [31:0] newcfg = 0, input int exp_len = 0);
    int n;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (chg) cfg_timing = newcfg;
    n = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      n++;
    end
    if (chg) chk(n == exp_len, "R11", n, exp_len);
  endtask

  initial begin
    logic [31:0] t1, tmax;
    t1   = mkcfg(2, 3, 1, 1, 4, 2, 3);
    tmax = mkcfg(15, 63, 7, 15, 63, 7, 3);
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    cfg_nand_en = 0; cfg_timing = '0; nand_dq_in = '0; nand_rb = 1;
    repeat (4) @(negedge clk);
    #5;
    // R1: idle pins under reset
    chk(nand_ce_n == 1, "R1", int'(nand_ce_n), 1);
    chk(nand_we_n == 1, "R1", int'(nand_we_n), 1);
    chk(nand_re_n == 1, "R1", int'(nand_re_n), 1);
    chk(!nand_cle && !nand_ale, "R1", int'(nand_cle | nand_ale), 0);
    chk(nand_dq_oe == 0, "R1", int'(nand_dq_oe), 0);
    chk(rsp_valid == 0, "R1", int'(rsp_valid), 0);
    chk(rdy_status == 0, "R1", int'(rdy_status), 0);
    @(negedge clk);
    rst_n = 1;
    run = 1;
    // R2: request held while flash mode is off is never taken
    cfg_timing = t1;
    req_valid = 1; req_write = 1; req_addr = 16'h0010; req_wdata = 8'h77;
    repeat (6) @(negedge clk);
    req_valid = 0;
    cfg_nand_en = 1;
    // R3 R4 R7: command and address writes
    op(1, 16'h0010, 8'hA5);
    op(1, 16'h0008, 8'h3C);
    // R5 R6 R7: read with only the ignored low bits set
    op(0, 16'h0003, 8'h00);
    // R9: write after read gets the turnaround gap
    op(1, 16'h0000, 8'h5A);
    op(0, 16'h0000, 8'h00);
    op(0, 16'h0018, 8'h00);
    op(1, 16'h0013, 8'h81);
    op(1, 16'h0001, 8'hFF);
    // shortest phases
    cfg_timing = 32'h0;
    op(1, 16'h0010, 8'h12);
    op(0, 16'h0008, 8'h00);
    op(1, 16'h0002, 8'h34);
    // longest phases
    cfg_timing = tmax;
    op(0, 16'h0010, 8'h00);
    op(1, 16'h0018, 8'hC3);
    // R11: timing word changes mid-read; length follows the accepted word
    cfg_timing = t1;
    op(0, 16'h0008, 8'h00, 1, tmax, 10);
    cfg_timing = t1;
    op(1, 16'h0000, 8'h99);
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule